// File: doc/BRIEF.md
# Filtered Interrupt Aggregator

This block collects a set of active-low interrupt request lines, one per downstream channel, and turns them into one combined interrupt for an upstream host. Each line first crosses into the system clock through a short synchronizer chain and then passes a glitch filter. The filter accepts a new level only after it has stayed put for a set number of clock cycles, and the count differs for the two directions: a line must stay low for the assert window before it counts as an interrupt, and it must stay high for the release window before that interrupt is dropped.

The filtered levels drive two outputs. The first is a pull-down enable for an open-drain interrupt pad. It is active whenever any filtered channel is active, so the pad behaves as the AND of the active-low inputs. The second is a per-channel pending vector that a register block can read. Detection does not depend on which channel the surrounding mux has selected. Nothing is latched: a channel stops pending only when its source releases the line. Both windows are parameters in system-clock cycles. At 250 MHz the defaults of 250 and 125 cycles give 1 µs low rejection and 0.5 µs high rejection.

Top module: `irq_glitch_merge`

## Requirements
- R1: While reset is applied and right after it, `irq_pending` is all zeros and `irq_pull_low` is 0. Reset is asynchronous and active low.
- R2: If input line i goes low and stays low, `irq_pending[i]` becomes 1 exactly `LOW_REJECT_CYC + SYNC_STAGES` rising clock edges after the first edge that samples the low level. This bounds the assert latency.
- R3: A low pulse that covers fewer than `LOW_REJECT_CYC` sampling edges never sets the pending bit. A high gap of even one cycle restarts the count, so two short low pulses do not add together.
- R4: Once line i is high again and stays high, `irq_pending[i]` clears exactly `HIGH_REJECT_CYC + SYNC_STAGES` rising edges after the first edge that samples the high level. This bounds the release latency.
- R5: While a channel is pending, a high pulse that covers fewer than `HIGH_REJECT_CYC` sampling edges does not clear it.
- R6: `irq_pull_low` is 1 exactly when at least one bit of `irq_pending` is 1. This gives the open-drain AND of the active-low inputs.
- R7: Each channel is filtered on its own. Bit i of `irq_pending` follows only input bit i, and any number of bits can be 1 at the same time. No channel-select input exists, and detection works on every channel at all times.
- R8: Nothing is latched. A pending bit stays 1 only while its filtered line is low and clears by itself after release, without any other action.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in_n | input | NUM_CH | Raw active-low interrupt request lines; bit i belongs to channel i |
| irq_pull_low | output | 1 | 1 = pull the shared open-drain interrupt pad low |
| irq_pending | output | NUM_CH | Filtered per-channel status; bit i = 1 means channel i has an accepted interrupt |

## Verification
The bench builds the block with `LOW_REJECT_CYC = 6`, `HIGH_REJECT_CYC = 3` and two synchronizer stages. With these values the exact assert latency of 8 cycles and release latency of 5 cycles fit in short vectors. The bench can then place pulses exactly one cycle below and exactly at each window: a 5-cycle low glitch, a 6-cycle low pulse, a 2-cycle high dip, and a split 5+5 low pulse with a one-cycle gap. It also drives overlapping channel patterns and applies reset while all lines are low.

// File: rtl/irqm_pkg.sv
package irqm_pkg;

    // Counter width large enough to hold the larger of the two windows.
    function automatic int cnt_width(input int a, input int b);
        int m;
        m = (a > b) ? a : b;
        return $clog2(m + 1) + 1;
    endfunction

endpackage

// File: rtl/irqm_sync.sv
module irqm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], din};
    end

    // Reset to the inactive (high) level of an active-low request.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/irqm_filter.sv
module irqm_filter
    import irqm_pkg::*;
#(
    parameter int LOW_REJECT_CYC  = 250,
    parameter int HIGH_REJECT_CYC = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_low,   // synchronized, 1 = request line is low
    output logic active      // filtered level, 1 = interrupt accepted
);

    localparam int CW = cnt_width(LOW_REJECT_CYC, HIGH_REJECT_CYC);
    localparam logic [CW-1:0] ASSERT_LAST  = CW'(LOW_REJECT_CYC - 1);
    localparam logic [CW-1:0] RELEASE_LAST = CW'(HIGH_REJECT_CYC - 1);

    typedef struct packed {
        logic          active;
        logic [CW-1:0] cnt;
    } filt_t;

    filt_t st_d, st_q;
    logic [CW-1:0] last_d;

    always_comb begin
        st_d   = st_q;
        last_d = st_q.active ? RELEASE_LAST : ASSERT_LAST;
        if (line_low == st_q.active) begin
            st_d.cnt = '0;
        end else if (st_q.cnt >= last_d) begin
            st_d.active = line_low;
            st_d.cnt    = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{active: 1'b0, cnt: '0};
        else        st_q <= st_d;
    end

    assign active = st_q.active;

    // R3 / R5: counter never runs past the window of its current direction
    a_r3_cnt_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= (st_q.active ? RELEASE_LAST : ASSERT_LAST));

    // R2: acceptance of an interrupt only follows a low synchronized line
    a_r2_assert_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.active) |-> $past(line_low));

    // R4: release only follows a high synchronized line
    a_r4_release_needs_high: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.active) |-> !$past(line_low));

    // R8: while the line agrees with the filtered level, nothing changes
    a_r8_hold_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        (line_low == st_q.active) |=> $stable(st_q.active));

endmodule

// File: rtl/irq_glitch_merge.sv
module irq_glitch_merge #(
    parameter int NUM_CH          = 4,
    parameter int SYNC_STAGES     = 2,
    parameter int LOW_REJECT_CYC  = 250,
    parameter int HIGH_REJECT_CYC = 125
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] irq_in_n,
    output logic              irq_pull_low,
    output logic [NUM_CH-1:0] irq_pending
);

    logic [NUM_CH-1:0] synced_n;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        irqm_sync #(
            .STAGES(SYNC_STAGES)
        ) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (irq_in_n[ch]),
            .dout (synced_n[ch])
        );

        irqm_filter #(
            .LOW_REJECT_CYC (LOW_REJECT_CYC),
            .HIGH_REJECT_CYC(HIGH_REJECT_CYC)
        ) u_filt (
            .clk     (clk),
            .rst_n   (rst_n),
            .line_low(~synced_n[ch]),
            .active  (irq_pending[ch])
        );
    end

    // Open-drain AND of active-low lines: pull down when any channel pends.
    assign irq_pull_low = |irq_pending;

    // R6: the pad drive and the pending vector agree at every clock edge
    a_r6_pad_tracks_pending: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pull_low == ($countones(irq_pending) != 0));

endmodule

// File: tb/tb_irq_glitch_merge.sv
module tb_irq_glitch_merge;

    localparam int NCH = 4;
    localparam int LOWC = 6;
    localparam int HIGHC = 3;

    // {lines_n[3:0], hold[7:0], exp_pull, exp_pend[3:0], req[7:0]}
    localparam int NV = 19;
    localparam logic [24:0] VECS [0:NV-1] = '{
        {4'hF, 8'd4, 1'b0, 4'h0, 8'd1},  // R1 idle after reset
        {4'hE, 8'd7, 1'b0, 4'h0, 8'd2},  // R2 one cycle before latency
        {4'hE, 8'd1, 1'b1, 4'h1, 8'd2},  // R2 accepted at cycle 8
        {4'hF, 8'd4, 1'b1, 4'h1, 8'd4},  // R4 one cycle before release
        {4'hF, 8'd1, 1'b0, 4'h0, 8'd4},  // R4 released at cycle 5
        {4'hB, 8'd5, 1'b0, 4'h0, 8'd3},  // R3 5-cycle low glitch
        {4'hF, 8'd1, 1'b0, 4'h0, 8'd3},  // R3 one-cycle gap
        {4'hB, 8'd5, 1'b0, 4'h0, 8'd3},  // R3 second 5-cycle glitch
        {4'hF, 8'd8, 1'b0, 4'h0, 8'd3},  // R3 pieces never combine
        {4'h5, 8'd8, 1'b1, 4'hA, 8'd7},  // R7 two channels at once
        {4'h7, 8'd2, 1'b1, 4'hA, 8'd5},  // R5 2-cycle high dip on ch1
        {4'h5, 8'd6, 1'b1, 4'hA, 8'd5},  // R5 ch1 still pending
        {4'h7, 8'd5, 1'b1, 4'h8, 8'd7},  // R7 only ch1 releases
        {4'hF, 8'd5, 1'b0, 4'h0, 8'd8},  // R8 clears with no action
        {4'h0, 8'd8, 1'b1, 4'hF, 8'd7},  // R7 all channels
        {4'hF, 8'd5, 1'b0, 4'h0, 8'd6},  // R6 pad released
        {4'hE, 8'd6, 1'b0, 4'h0, 8'd2},  // R2 exactly 6-cycle low pulse
        {4'hF, 8'd2, 1'b1, 4'h1, 8'd2},  // R2 boundary pulse accepted
        {4'hF, 8'd3, 1'b0, 4'h0, 8'd4}   // R4 then released
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NCH-1:0] lines_n = '1;
    logic pull_low;
    logic [NCH-1:0] pending;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    irq_glitch_merge #(
        .NUM_CH         (NCH),
        .SYNC_STAGES    (2),
        .LOW_REJECT_CYC (LOWC),
        .HIGH_REJECT_CYC(HIGHC)
    ) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_in_n    (lines_n),
        .irq_pull_low(pull_low),
        .irq_pending (pending)
    );

    task automatic check(input int req, input logic exp_pull, input logic [NCH-1:0] exp_pend);
        checks++;
        if (pull_low !== exp_pull || pending !== exp_pend) begin
            fails++;
            $display("FAIL R%0d: pull_low=%0b pending=%h expected pull_low=%0b pending=%h",
                     req, pull_low, pending, exp_pull, exp_pend);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(1, 1'b0, 4'h0);             // R1 during reset
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            lines_n = VECS[v][24:21];
            repeat (int'(VECS[v][20:13])) @(negedge clk);
            check(int'(VECS[v][7:0]), VECS[v][12], VECS[v][11:8]);
        end

        // R1: asynchronous reset clears accepted interrupts at once
        lines_n = 4'h0;
        repeat (8) @(negedge clk);
        check(7, 1'b1, 4'hF);
        #1 rst_n = 1'b0;
        #0.5;
        check(1, 1'b0, 4'h0);
        @(negedge clk);
        rst_n = 1'b1;
        // R2: low lines held through reset are accepted after the full latency
        repeat (7) @(negedge clk);
        check(2, 1'b0, 4'h0);
        @(negedge clk);
        check(2, 1'b1, 4'hF);
        lines_n = 4'hF;
        repeat (5) @(negedge clk);
        check(8, 1'b0, 4'h0);            // R8

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule